// File: doc/BRIEF.md
# Parallel Port Register and Control-Word Decoder

This block gives a processor three 8-bit general-purpose parallel ports (A, B and C) behind a small register window. The processor reaches it through an 8-bit data bus, a two-bit register address and active-low select, read and write strobes. The register at address 3 is a control register. A word written there either sets the direction of port A, port B and each 4-bit half of port C, or sets or clears a single bit of the port C output latch. Bit 7 of the word chooses between the two.

Each port pin has an output value and an output enable. A chip-level pad ring combines these with the pin input into a tri-state pin. Only plain, unhandshaked transfers are handled here. Handshake sequencing is done by other blocks. The data bus is also split into input, output and enable, so the pad or bus fabric can resolve it.

Top module: `pio_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the control register becomes 9Bh and every output latch becomes 0. After reset all output enables are 0, and a read of address 3 returns 9Bh.
- R2: `d_oe` is 1 exactly when `cs_n` and `rd_n` are both low. While it is 1, `d_o` carries the selected register.
- R3: State changes only at a rising clock edge where `cs_n` and `wr_n` are both low. With either strobe high, latches and directions hold.
- R4: Address 0 selects port A, address 1 selects port B, address 2 selects port C and address 3 selects the control register, for both reads and writes.
- R5: A control write with bit 7 = 1 stores the whole word as the mode word, which reads back at address 3. The word sets these directions, where 1 means input: bit 4 for port A, bit 3 for port C bits 7:4, bit 1 for port B, and bit 0 for port C bits 3:0. For example, 98h makes port A and the upper half of port C inputs, and makes port B and the lower half of port C outputs.
- R6: A mode-word write clears all three output latches to 0 at the same edge.
- R7: A control write with bit 7 = 0 is a bit command. Bits 3:1 give the port C bit index and bit 0 gives the new value, so 0Ah clears bit 5. No other latch bit changes, and the mode word is left as it was.
- R8: Each port's `*_o` equals its output latch. Each output enable bit is 1 exactly when that bit's port or half-port is set to output.
- R9: A port read returns the latch bit for each bit set to output, and the pin input (`*_i`) as it is during that read for each bit set to input. Port C is resolved per half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| d_i | input | 8 | Data bus in |
| d_o | output | 8 | Data bus out |
| d_oe | output | 1 | Data bus drive enable |
| pa_i | input | 8 | Port A pin input |
| pa_o | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin input |
| pb_o | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin input |
| pc_o | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
A single read of port C can return latch readback and live pin sampling at once, when its two halves point in opposite directions. The bench provokes this with all sixteen direction patterns, including 98h. It loads the latch with one pattern and drives a different pattern on the pins. It then expects each half of the returned byte to come from the correct source. A bit command landing on a port C bit that is set to input is judged in the same way: the latch and `pc_o` must change, while a read of that half must still show the pin.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int DW       = 8;
    localparam int NPORT    = 3;
    localparam int HALF     = DW / 2;
    localparam int IDXW     = $clog2(DW);
    localparam int AW       = $clog2(NPORT + 1);
    localparam int PORT_C   = NPORT - 1;
    localparam logic [DW-1:0] RESET_WORD = 8'h9B;

    typedef enum logic [AW-1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } sel_e;

    typedef struct packed {
        logic       is_mode;
        logic [1:0] grp_a_mode;
        logic       a_in;
        logic       cu_in;
        logic       grp_b_mode;
        logic       b_in;
        logic       cl_in;
    } mode_t;

    typedef struct packed {
        logic            is_mode;
        logic [2:0]      spare;
        logic [IDXW-1:0] idx;
        logic            val;
    } bitcmd_t;

    function automatic logic [DW-1:0] oe_mask(mode_t m, int p);
        logic [DW-1:0] r;
        case (p)
            0:       r = {DW{~m.a_in}};
            1:       r = {DW{~m.b_in}};
            default: r = {{HALF{~m.cu_in}}, {HALF{~m.cl_in}}};
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] rd_merge(logic [DW-1:0] lat,
                                               logic [DW-1:0] pin,
                                               logic [DW-1:0] oe);
        return (lat & oe) | (pin & ~oe);
    endfunction
endpackage

// File: rtl/pio_bus_dec.sv
module pio_bus_dec
    import pio_pkg::*;
(
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [AW-1:0]    addr,
    output logic [NPORT-1:0] wr_port,
    output logic             wr_ctl,
    output logic             rd_en,
    output sel_e             rd_sel
);
    logic wr_any;

    assign wr_any = ~cs_n & ~wr_n;
    assign rd_en  = ~cs_n & ~rd_n;
    assign rd_sel = sel_e'(addr);
    assign wr_ctl = wr_any && (sel_e'(addr) == SEL_CTL);

    for (genvar g = 0; g < NPORT; g++) begin : g_wsel
        assign wr_port[g] = wr_any && (addr == AW'(g));
    end
endmodule

// File: rtl/pio_ctl_reg.sv
module pio_ctl_reg
    import pio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_ctl,
    input  logic [DW-1:0]   wdata,
    output mode_t           mode,
    output logic            clr_lat,
    output logic            bit_wr,
    output logic [IDXW-1:0] bit_idx,
    output logic            bit_val
);
    bitcmd_t cmd;

    assign cmd     = bitcmd_t'(wdata);
    assign clr_lat = wr_ctl &  cmd.is_mode;
    assign bit_wr  = wr_ctl & ~cmd.is_mode;
    assign bit_idx = cmd.idx;
    assign bit_val = cmd.val;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= mode_t'(RESET_WORD);
        end else if (clr_lat) begin
            mode <= mode_t'(wdata);
        end
    end
endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch
    import pio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            wr,
    input  logic [DW-1:0]   wdata,
    input  logic            bit_wr,
    input  logic [IDXW-1:0] bit_idx,
    input  logic            bit_val,
    output logic [DW-1:0]   q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (wr) begin
            q <= wdata;
        end else if (bit_wr) begin
            q[bit_idx] <= bit_val;
        end
    end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
    import pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [7:0]    d_i,
    output logic [7:0]    d_o,
    output logic          d_oe,
    input  logic [7:0]    pa_i,
    output logic [7:0]    pa_o,
    output logic [7:0]    pa_oe,
    input  logic [7:0]    pb_i,
    output logic [7:0]    pb_o,
    output logic [7:0]    pb_oe,
    input  logic [7:0]    pc_i,
    output logic [7:0]    pc_o,
    output logic [7:0]    pc_oe
);
    logic [NPORT-1:0] wr_port;
    logic             wr_ctl;
    logic             rd_en;
    sel_e             rd_sel;
    mode_t            mode;
    logic             clr_lat;
    logic             bit_wr;
    logic [IDXW-1:0]  bit_idx;
    logic             bit_val;
    logic [DW-1:0]    lat_q  [NPORT];
    logic [DW-1:0]    pin_i  [NPORT];
    logic [DW-1:0]    oe     [NPORT];
    logic [DW-1:0]    rd_val [NPORT];

    pio_bus_dec u_dec (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .wr_port (wr_port),
        .wr_ctl  (wr_ctl),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel)
    );

    pio_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctl  (wr_ctl),
        .wdata   (d_i),
        .mode    (mode),
        .clr_lat (clr_lat),
        .bit_wr  (bit_wr),
        .bit_idx (bit_idx),
        .bit_val (bit_val)
    );

    assign pin_i[0] = pa_i;
    assign pin_i[1] = pb_i;
    assign pin_i[2] = pc_i;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        pio_out_latch u_lat (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr_lat),
            .wr      (wr_port[g]),
            .wdata   (d_i),
            .bit_wr  (bit_wr && (g == PORT_C)),
            .bit_idx (bit_idx),
            .bit_val (bit_val),
            .q       (lat_q[g])
        );
        assign oe[g]     = oe_mask(mode, g);
        assign rd_val[g] = rd_merge(lat_q[g], pin_i[g], oe[g]);
    end

    assign pa_o  = lat_q[0];
    assign pb_o  = lat_q[1];
    assign pc_o  = lat_q[2];
    assign pa_oe = oe[0];
    assign pb_oe = oe[1];
    assign pc_oe = oe[2];

    always_comb begin
        case (rd_sel)
            SEL_A:   d_o = rd_val[0];
            SEL_B:   d_o = rd_val[1];
            SEL_C:   d_o = rd_val[2];
            default: d_o = mode;
        endcase
    end
    assign d_oe = rd_en;
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] d_i,
    input logic       d_oe,
    input logic [7:0] pa_o,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_o,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_o,
    input logic [7:0] pc_oe
);
    logic ctl_wr;
    assign ctl_wr = !cs_n && !wr_n && (addr == 2'd3);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
                 pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00));

    a_r2_bus_drive: assert property (@(posedge clk) disable iff (rst)
        d_oe == (!cs_n && !rd_n));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (cs_n || wr_n) |=> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o) &&
                            $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    a_r5_dir_a: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && d_i[7]) |=> (pa_oe == {8{~$past(d_i[4])}}));

    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && d_i[7]) |=> (pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00));

    a_r7_bit_value: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !d_i[7]) |=> (pc_o[$past(d_i[3:1])] == $past(d_i[0])));

    a_r7_mode_kept: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !d_i[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    a_r8_whole_port: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF));
endmodule

bind pio_ctrl pio_ctrl_chk u_chk (.*);

// File: tb/sim_pio_ctrl.sv
`timescale 1ns/1ps
module sim_pio_ctrl;
    localparam real HALF_P = 2.5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] d_i = '0;
    logic [7:0] d_o;
    logic       d_oe;
    logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
    logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_ctl;
    logic [7:0] m_lat [3];

    always #(HALF_P) clk = ~clk;

    pio_ctrl u0 (.*);

    function automatic logic [7:0] exp_oe(int p);
        case (p)
            0:       return {8{~m_ctl[4]}};
            1:       return {8{~m_ctl[1]}};
            default: return {{4{~m_ctl[3]}}, {4{~m_ctl[0]}}};
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(int p, logic [7:0] pin);
        logic [7:0] o;
        o = exp_oe(p);
        return (m_lat[p] & o) | (pin & ~o);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; d_i = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        #0.5;
        if (a == 2'd3) begin
            if (d[7]) begin
                m_ctl = d;
                foreach (m_lat[i]) m_lat[i] = 8'h00;
            end else begin
                m_lat[2][d[3:1]] = d[0];
            end
        end else begin
            m_lat[a] = d;
        end
    endtask

    task automatic bus_rd(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #0.5;
        v = d_o;
        chk("R2 d_oe during read", {7'd0, d_oe}, 8'd1);
        cs_n = 1'b1; rd_n = 1'b1;
        #0.2;
        chk("R2 d_oe after read", {7'd0, d_oe}, 8'd0);
    endtask

    task automatic chk_outputs(string tag);
        chk({tag, " R8 pa_o"}, pa_o, m_lat[0]);
        chk({tag, " R8 pb_o"}, pb_o, m_lat[1]);
        chk({tag, " R8 pc_o"}, pc_o, m_lat[2]);
        chk({tag, " R8 pa_oe"}, pa_oe, exp_oe(0));
        chk({tag, " R8 pb_oe"}, pb_oe, exp_oe(1));
        chk({tag, " R8 pc_oe"}, pc_oe, exp_oe(2));
    endtask

    task automatic rd_port(int p, string tag);
        logic [7:0] v;
        pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
        bus_rd(2'(p), v);
        case (p)
            0: chk({tag, " R9 R4 read A"}, v, exp_rd(0, pa_i));
            1: chk({tag, " R9 R4 read B"}, v, exp_rd(1, pb_i));
            2: chk({tag, " R9 R4 read C"}, v, exp_rd(2, pc_i));
            default: chk({tag, " R5 R4 read ctl"}, v, m_ctl);
        endcase
    endtask

    initial begin
        #(HALF_P * 2 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        m_ctl = 8'h9B;
        foreach (m_lat[i]) m_lat[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.5;
        chk_outputs("R1 reset");
        chk("R1 d_oe idle", {7'd0, d_oe}, 8'd0);
        bus_rd(2'd3, v);
        chk("R1 ctl after reset", v, 8'h9B);
        rd_port(0, "R1 all input");
        rd_port(2, "R1 all input");

        // directed 98h
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd2, 8'hA5);
        bus_wr(2'd3, 8'h98);
        chk_outputs("R5 R6 98h");
        chk("R5 98h pc_oe", pc_oe, 8'h0F);
        chk("R6 98h latch C", pc_o, 8'h00);
        bus_wr(2'd2, 8'h3C);
        pc_i = 8'hC3;
        bus_rd(2'd2, v);
        chk("R9 98h mixed halves", v, 8'hCC);

        // all sixteen direction patterns
        for (int m = 0; m < 16; m++) begin
            logic [7:0] w;
            bus_wr(2'd0, 8'($urandom));
            bus_wr(2'd1, 8'($urandom));
            bus_wr(2'd2, 8'($urandom));
            w = {1'b1, 2'($urandom), m[3], m[2], 1'($urandom), m[1], m[0]};
            bus_wr(2'd3, w);
            chk_outputs("R5 R6 dir");
            chk("R6 clear C", pc_o, 8'h00);
            bus_wr(2'd0, 8'($urandom));
            bus_wr(2'd1, 8'($urandom));
            bus_wr(2'd2, 8'($urandom));
            chk_outputs("R4 R8 dir");
            for (int p = 0; p < 4; p++) rd_port(p, "dir");
        end

        // all sixteen bit commands, port C all output then mixed
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd2, 8'($urandom));
        for (int c = 0; c < 16; c++) begin
            bus_wr(2'd3, 8'(c));
            chk("R7 bit cmd pc_o", pc_o, m_lat[2]);
            chk("R7 mode kept pc_oe", pc_oe, 8'hFF);
            bus_rd(2'd3, v);
            chk("R7 mode word unchanged", v, 8'h80);
        end
        bus_wr(2'd2, 8'hFF);
        bus_wr(2'd3, 8'h0A);
        chk("R7 0Ah clears bit 5", pc_o, 8'hDF);
        bus_wr(2'd3, 8'h89);
        for (int c = 0; c < 16; c++) begin
            bus_wr(2'd3, 8'(c ^ 1));
            chk("R7 bit cmd on input half", pc_o, m_lat[2]);
            rd_port(2, "R7 input half");
        end

        // strobe gating
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd0, 8'h5A);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; d_i = 8'hFF;
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b1; d_i = 8'h12;
        #0.5;
        chk("R2 no drive without rd", {7'd0, d_oe}, 8'd0);
        @(negedge clk);
        cs_n = 1'b1; addr = 2'd3; d_i = 8'h9B;
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        #0.5;
        chk_outputs("R3 gated");
        chk("R3 pa_o held", pa_o, 8'h5A);

        // random mix
        for (int k = 0; k < 400; k++) begin
            case ($urandom % 4)
                0: bus_wr(2'd3, 8'h80 | 8'($urandom));
                1: bus_wr(2'd3, 8'($urandom) & 8'h7F);
                2: bus_wr(2'($urandom % 3), 8'($urandom));
                default: rd_port(int'($urandom % 4), "rand");
            endcase
            chk_outputs("rand");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule